// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It has a table of 2-bit saturating counters and a global history register. The history register holds the outcomes of the most recently resolved branches. A lookup XORs the word-address bits of the branch PC with the whole history. That index picks one counter, and the upper bit of that counter is the prediction. The lookup path is combinational, so the prediction appears in the same cycle as the PC.

The fetch stage keeps the index returned with each prediction and sends it back when the branch resolves. The resolve port bumps the chosen counter up or down and shifts the real outcome into the history. The update reaches the same counter that made the guess, even after the history has moved on. The history length `HIST_W` sets the table depth, which is 2^`HIST_W` entries. It also sets how many PC bits enter the hash.

Top module: `gshare_predictor`

## Requirements
- R1: After reset the history register is all zeros. Every table entry at an even index holds 01 (weakly not taken), and every entry at an odd index holds 10 (weakly taken).
- R2: The lookup index `pred_idx_o` equals `pred_pc_i` XOR `ghist_o`. Here `pred_pc_i` carries PC bits [HIST_W+1:2], and the two byte-offset bits are not part of the port.
- R3: `pred_ctr_o` shows the counter at the lookup index. `pred_taken_o` is its bit 1: 1 means taken, 0 means not taken.
- R4: On a clock edge with `upd_valid_i` high, the counter at `upd_idx_i` goes up by one when `upd_taken_i` is 1 and down by one when it is 0. All other counters keep their values.
- R5: A counter at 11 stays at 11 on a taken update. A counter at 00 stays at 00 on a not-taken update.
- R6: On each update the history shifts left by one bit, and `upd_taken_i` enters at bit 0.
- R7: An update writes the entry named by `upd_idx_i`, whatever the current history and lookup PC are.
- R8: When a lookup and an update select the same entry in one cycle, the lookup shows the counter value from before the update.
- R9: While `upd_valid_i` is low, neither the counters nor the history change, whatever `upd_idx_i` and `upd_taken_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | HIST_W | Branch PC bits [HIST_W+1:2] for lookup |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_ctr_o | output | 2 | Counter at the lookup index |
| pred_idx_o | output | HIST_W | Table index used by this lookup |
| upd_valid_i | input | 1 | Resolve strobe |
| upd_idx_i | input | HIST_W | Index captured when the branch was predicted |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| ghist_o | output | HIST_W | Global history register |

## Verification
Some behaviours are checked by assertions on every cycle:
- the history shifts on each update and holds while the strobe is low;
- an updated counter moves by exactly one step in the direction of the outcome;
- a counter at either end stays there when pushed further in the same direction.

Other behaviours only the bench scenarios can show:
- the alternating reset pattern;
- the XOR index across every PC and history value;
- writes that use a stale index;
- a lookup and an update hitting the same entry in one cycle.

For these, the bench compares every table entry against its own model after each update.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == CTR_ST)  ? c : c + 2'd1;
    else       return (c == CTR_SNT) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/gshare_hist.sv
module gshare_hist #(
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], taken_i};
  end

  assign hist_o = hist_q;

  assert_hist_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (hist_o[0] == $past(taken_i)) &&
                (hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0])));

  assert_hist_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_o));
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t cnt [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam ctr_t RST_VAL = (g % 2 == 1) ? CTR_WT : CTR_WNT;
    ctr_t e_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) e_q <= RST_VAL;
      else if (we_i && (wr_idx_i == IDX_W'(g))) e_q <= ctr_step(e_q, wr_taken_i);
    end
    assign cnt[g] = e_q;
  end

  // Read sees the stored value; a same-cycle write lands at the edge.
  assign rd_ctr_o = cnt[rd_idx_i];

  // Write tracker for the assertions below.
  logic             chk_we_q, chk_tk_q;
  logic [IDX_W-1:0] chk_idx_q;
  ctr_t             chk_old_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_we_q  <= 1'b0;
      chk_tk_q  <= 1'b0;
      chk_idx_q <= '0;
      chk_old_q <= CTR_SNT;
    end else begin
      chk_we_q  <= we_i;
      chk_tk_q  <= wr_taken_i;
      chk_idx_q <= wr_idx_i;
      chk_old_q <= cnt[wr_idx_i];
    end
  end

  assert_ctr_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_we_q && chk_tk_q && chk_old_q != CTR_ST) |-> cnt[chk_idx_q] == chk_old_q + 2'd1);

  assert_ctr_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_we_q && !chk_tk_q && chk_old_q != CTR_SNT) |-> cnt[chk_idx_q] == chk_old_q - 2'd1);

  assert_sat_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_we_q && chk_tk_q && chk_old_q == CTR_ST) |-> cnt[chk_idx_q] == CTR_ST);

  assert_sat_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_we_q && !chk_tk_q && chk_old_q == CTR_SNT) |-> cnt[chk_idx_q] == CTR_SNT);
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W+1:2] pred_pc_i,
  output logic              pred_taken_o,
  output logic [1:0]        pred_ctr_o,
  output logic [HIST_W-1:0] pred_idx_o,
  input  logic              upd_valid_i,
  input  logic [HIST_W-1:0] upd_idx_i,
  input  logic              upd_taken_i,
  output logic [HIST_W-1:0] ghist_o
);
  localparam int IDX_W = HIST_W;

  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  lk_idx;
  ctr_t              lk_ctr;

  gshare_hist #(.HIST_W(HIST_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .taken_i (upd_taken_i),
    .hist_o  (ghist)
  );

  assign lk_idx = pred_pc_i ^ ghist;

  gshare_pht #(.IDX_W(IDX_W)) u_pht (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_idx),
    .rd_ctr_o   (lk_ctr),
    .we_i       (upd_valid_i),
    .wr_idx_i   (upd_idx_i),
    .wr_taken_i (upd_taken_i)
  );

  assign pred_idx_o   = lk_idx;
  assign pred_ctr_o   = lk_ctr;
  assign pred_taken_o = lk_ctr[1];
  assign ghist_o      = ghist;
endmodule

// File: tb/gshare_predictor_tb.sv
`timescale 1ns/1ps
module gshare_predictor_tb;
  localparam int HW = 4;
  localparam int DEPTH = 1 << HW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [HW+1:2] pred_pc_i = '0;
  logic          pred_taken_o;
  logic [1:0]    pred_ctr_o;
  logic [HW-1:0] pred_idx_o;
  logic          upd_valid_i = 1'b0;
  logic [HW-1:0] upd_idx_i = '0;
  logic          upd_taken_i = 1'b0;
  logic [HW-1:0] ghist_o;

  gshare_predictor #(.HIST_W(HW)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [1:0]    m_ctr [DEPTH];
  logic [HW-1:0] m_hist;
  logic [7:0]    lfsr = 8'hA5;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] m_step(logic [1:0] c, logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic lookup_all(string req);
    for (int pc = 0; pc < DEPTH; pc++) begin
      int ei;
      pred_pc_i = HW'(pc);
      #0.2;
      ei = pc ^ int'(m_hist);
      chk({req, "/R2 idx"}, int'(pred_idx_o), ei);
      chk({req, "/R3 ctr"}, int'(pred_ctr_o), int'(m_ctr[ei]));
      chk({req, "/R3 taken"}, int'(pred_taken_o), int'(m_ctr[ei][1]));
    end
    chk({req, "/R6 hist"}, int'(ghist_o), int'(m_hist));
  endtask

  task automatic update(logic [HW-1:0] idx, logic t);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_idx_i = idx; upd_taken_i = t;
    @(posedge clk_i); #1;
    upd_valid_i = 1'b0;
    m_ctr[idx] = m_step(m_ctr[idx], t);
    m_hist = {m_hist[HW-2:0], t};
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = (i % 2 == 1) ? 2'b10 : 2'b01;
    m_hist = '0;
    #20 rst_ni = 1'b1;
    #1;
    lookup_all("R1 reset");

    // R5 saturation high then low on one entry, R4 step
    for (int k = 0; k < 5; k++) begin
      update(HW'(3), 1'b1);
      lookup_all("R4 R5 up");
    end
    for (int k = 0; k < 5; k++) begin
      update(HW'(3), 1'b0);
      lookup_all("R4 R5 down");
    end

    // R7 stale indices: pseudo-random index/outcome stream, full sweep after each
    for (int k = 0; k < 150; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      update(lfsr[HW-1:0], lfsr[HW] | lfsr[HW+1]);
      lookup_all("R7 stream");
    end

    // R9 idle strobe: inputs toggle, nothing should move
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      upd_idx_i = HW'(k); upd_taken_i = k[0];
    end
    @(negedge clk_i);
    lookup_all("R9 idle");

    // R8 same-entry lookup and update in one cycle
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk_i);
      pred_pc_i = HW'(k) ^ m_hist;
      upd_valid_i = 1'b1; upd_idx_i = HW'(k); upd_taken_i = ~m_ctr[k][1];
      #1;
      chk("R8 old value", int'(pred_ctr_o), int'(m_ctr[k]));
      @(posedge clk_i); #1;
      upd_valid_i = 1'b0;
      m_ctr[k] = m_step(m_ctr[k], upd_taken_i);
      m_hist = {m_hist[HW-2:0], upd_taken_i};
    end
    lookup_all("R8 after");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule